// File: doc/BRIEF.md
# Card Clock Source Selector and Divider

This block produces the clock that drives a smart card. It picks one source through a strict priority order. An internal reference comes first, then a forced low level, then a forced high level, and last a divided copy of an external input clock. A three-bit ratio code selects pass-through, divide by 2, 4 or 5, or divide by 8. All codes with the top bit set give divide by 8. A separate synchronous-card mode skips the divider. In that mode the output either follows the input clock directly or sits at a static level.

The whole block runs on one fast system clock. The external input clock and the internal reference arrive as sampled levels. The card clock is a registered output. A change of source or ratio is held pending until the card clock is low, so the running high phase is never cut short. The one exception is leaving a forced-high level, which can be left at once. A status output shows when the internal reference is the source actually in use. While the card interface is inactive, the output is held low.

Top module: `cardclk_gen`

## Requirements
- R1: While `if_active` is 0, `card_clk` is 0 from the next system clock edge on, and `int_ref_active` is 0; both are 0 after reset.
- R2: In normal (non-synchronous) mode the source priority is: `sel_internal`=1 picks the internal reference; otherwise `force_low`=1 gives a static 0; otherwise `force_high`=1 gives a static 1; otherwise the divider output is used.
- R3: `int_ref_active` is 1 exactly while the applied source is the internal reference. In synchronous mode `sel_internal` is ignored, so the flag is 0.
- R4: Ratio code 3'b000 passes the external clock: `card_clk` equals the `ext_clk` level sampled at the same edge.
- R5: Code 3'b001 divides by 2 and code 3'b010 divides by 4, each with equal high and low times measured in input periods.
- R6: Code 3'b011 divides by 5: high for 2 input periods, then low for 3. The parameter `RESET_CODE` (default 3'b011) is the ratio held after reset.
- R7: Codes 3'b100 to 3'b111 all divide by 8 (high 4 input periods, low 4). Changing between two of these codes does not restart the divider.
- R8: In synchronous mode (`sync_mode`=1) with `sync_clk_en`=1, `card_clk` follows `ext_clk` whatever the ratio code and `sel_internal` are.
- R9: In synchronous mode with `sync_clk_en`=0, the output is static: 0 if `force_low`=1, else 1 if `force_high`=1, else 0.
- R10: A requested change of source or ratio is applied only on an edge where `card_clk` is 0, or where the applied source is the forced-high level. A high pulse in progress keeps its full length.
- R11: After a divided source (code not 3'b000) is applied, `card_clk` stays low until the next rising edge of `ext_clk`, and every rise of the divided output starts at such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Sampled level of the external input clock |
| int_ref | input | 1 | Sampled level of the internal reference clock |
| if_active | input | 1 | Card interface is active; 0 holds the output low |
| sync_mode | input | 1 | Synchronous-card operating mode |
| sync_clk_en | input | 1 | In synchronous mode, 1 passes the input clock |
| sel_internal | input | 1 | Request the internal reference (normal mode only) |
| force_low | input | 1 | Request a static low level |
| force_high | input | 1 | Request a static high level |
| div_code | input | 3 | Ratio code: 000 /1, 001 /2, 010 /4, 011 /5, 1xx /8 |
| card_clk | output | 1 | Registered clock driven toward the card |
| int_ref_active | output | 1 | The internal reference is the applied source |

## Verification
If the divider phase is wrong, a high or low stretch of `card_clk` comes out one or more input periods off. This shows within one output period, at most eight input periods. If the applied source register is wrong, the output shows either a high pulse that ends early or a switch that never happens. A reference model compares every cycle, so this shows on the first edge where the two differ. A wrong priority decode or status flag shows a few cycles after the change that exposes it, once the current high phase has ended.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    // Ratio code width is fixed by the code encoding (3 bits, 1xx folds to /8)
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned PHASE_W = 3;              // enough for a ratio of 8
    localparam int unsigned RATIO_W = PHASE_W + 1;

    typedef enum logic [2:0] {
        SRC_OFF  = 3'd0,
        SRC_INT  = 3'd1,
        SRC_LOW  = 3'd2,
        SRC_HIGH = 3'd3,
        SRC_EXT  = 3'd4,
        SRC_DIV  = 3'd5
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [CODE_W-1:0] code;
    } sel_t;

    function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] c);
        return c[CODE_W-1] ? 3'b100 : c;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        case (fold_code(c))
            3'b000:  r = 4'd1;
            3'b001:  r = 4'd2;
            3'b010:  r = 4'd4;
            3'b011:  r = 4'd5;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

    // number of input periods the divided output stays high
    function automatic logic [RATIO_W-1:0] high_len_of(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        r = ratio_of(c);
        return (r == 4'd1) ? 4'd1 : (r >> 1);
    endfunction

endpackage

// File: rtl/cardclk_request.sv
module cardclk_request
    import cardclk_pkg::*;
(
    input  logic              if_active,
    input  logic              sync_mode,
    input  logic              sync_clk_en,
    input  logic              sel_internal,
    input  logic              force_low,
    input  logic              force_high,
    input  logic [CODE_W-1:0] div_code,
    output sel_t              req
);

    always_comb begin
        req.src  = SRC_OFF;
        req.code = '0;
        if (if_active) begin
            if (sync_mode) begin
                // internal select has no meaning here
                if (sync_clk_en)     req.src = SRC_EXT;
                else if (force_low)  req.src = SRC_LOW;
                else if (force_high) req.src = SRC_HIGH;
                else                 req.src = SRC_LOW;
            end else begin
                if (sel_internal)    req.src = SRC_INT;
                else if (force_low)  req.src = SRC_LOW;
                else if (force_high) req.src = SRC_HIGH;
                else begin
                    req.src  = SRC_DIV;
                    req.code = fold_code(div_code);
                end
            end
        end
    end

endmodule

// File: rtl/cardclk_switch.sv
module cardclk_switch
    import cardclk_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic if_active,
    input  sel_t req,
    input  logic card_clk_q,
    output sel_t cur_d,
    output sel_t cur_q,
    output logic apply
);

    typedef struct packed {
        sel_t cur;
    } sw_state_t;

    sw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!if_active) begin
            // deactivation overrides at once
            st_d.cur.src = SRC_OFF;
        end else if ((req != st_q.cur) &&
                     (!card_clk_q || (st_q.cur.src == SRC_HIGH))) begin
            st_d.cur = req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur.src  <= SRC_OFF;
            st_q.cur.code <= RESET_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_d = st_d.cur;
    assign cur_q = st_q.cur;
    assign apply = (st_d.cur != st_q.cur);

    // a source change never lands while a high phase is running
    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q != $past(cur_q)) && (cur_q.src != SRC_OFF) &&
         ($past(cur_q.src) != SRC_HIGH)) |-> !$past(card_clk_q)); // R10

endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider
    import cardclk_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              apply,
    input  logic [CODE_W-1:0] code_d,
    output logic              ext_rise,
    output logic              div_level
);

    localparam logic [RATIO_W-1:0] RST_RATIO = ratio_of(RESET_CODE);

    typedef struct packed {
        logic               ext_q;
        logic [PHASE_W-1:0] phase;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [RATIO_W-1:0] last;

    always_comb begin
        st_d       = st_q;
        st_d.ext_q = ext_clk;
        ext_rise   = ext_clk && !st_q.ext_q;
        last       = ratio_of(code_d) - 4'd1;
        if (apply) begin
            // park on the final low phase so the first high starts at a rise
            st_d.phase = last[PHASE_W-1:0];
        end else if (ext_rise) begin
            if ({1'b0, st_q.phase} >= last) st_d.phase = '0;
            else                            st_d.phase = st_q.phase + 1'b1;
        end
        div_level = ({1'b0, st_d.phase} < high_len_of(code_d));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ext_q <= 1'b0;
            st_q.phase <= PHASE_W'(RST_RATIO - 4'd1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              int_ref,
    input  logic              if_active,
    input  logic              sync_mode,
    input  logic              sync_clk_en,
    input  logic              sel_internal,
    input  logic              force_low,
    input  logic              force_high,
    input  logic [CODE_W-1:0] div_code,
    output logic              card_clk,
    output logic              int_ref_active
);

    sel_t req, cur_d, cur_q;
    logic apply, ext_rise, div_level;
    logic out_d, out_q;

    cardclk_request u_req (
        .if_active    (if_active),
        .sync_mode    (sync_mode),
        .sync_clk_en  (sync_clk_en),
        .sel_internal (sel_internal),
        .force_low    (force_low),
        .force_high   (force_high),
        .div_code     (div_code),
        .req          (req)
    );

    cardclk_switch #(.RESET_CODE(RESET_CODE)) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_active  (if_active),
        .req        (req),
        .card_clk_q (out_q),
        .cur_d      (cur_d),
        .cur_q      (cur_q),
        .apply      (apply)
    );

    cardclk_divider #(.RESET_CODE(RESET_CODE)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .apply     (apply),
        .code_d    (cur_d.code),
        .ext_rise  (ext_rise),
        .div_level (div_level)
    );

    always_comb begin
        case (cur_d.src)
            SRC_INT:  out_d = int_ref;
            SRC_HIGH: out_d = 1'b1;
            SRC_EXT:  out_d = ext_clk;
            SRC_DIV:  out_d = (cur_d.code == 3'b000) ? ext_clk : div_level;
            default:  out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign card_clk       = out_q;
    assign int_ref_active = (cur_q.src == SRC_INT);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !if_active |=> !card_clk); // R1
    AST_STATUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !if_active |=> !int_ref_active); // R3
    AST_HIGH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.src == SRC_HIGH) |-> card_clk); // R2
    AST_LOW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.src == SRC_LOW) || (cur_q.src == SRC_OFF)) |-> !card_clk); // R9
    AST_DIV_RISE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.src == SRC_DIV) && (cur_q.code != 3'b000) && $rose(card_clk))
        |-> $past(ext_rise)); // R11

endmodule

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk = 1'b0, int_ref = 1'b0;
    logic if_active = 1'b0, sync_mode = 1'b0, sync_clk_en = 1'b0;
    logic sel_internal = 1'b0, force_low = 1'b0, force_high = 1'b0;
    logic [2:0] div_code = 3'b011;
    logic card_clk, int_ref_active;

    int checks = 0;
    int errors = 0;
    int ext_half = 3;
    int ext_cnt = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    cardclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .int_ref(int_ref),
        .if_active(if_active), .sync_mode(sync_mode), .sync_clk_en(sync_clk_en),
        .sel_internal(sel_internal), .force_low(force_low), .force_high(force_high),
        .div_code(div_code), .card_clk(card_clk), .int_ref_active(int_ref_active)
    );

    // input clock stimulus, changed away from the active edge
    always @(negedge clk) begin
        if (ext_cnt + 1 >= ext_half) begin ext_clk <= ~ext_clk; ext_cnt <= 0; end
        else ext_cnt <= ext_cnt + 1;
        if (ref_cnt + 1 >= 5) begin int_ref <= ~int_ref; ref_cnt <= 0; end
        else ref_cnt <= ref_cnt + 1;
    end

    // ---------------- reference model (source codes: 0 off,1 int,2 low,3 high,4 ext,5 div)
    int m_src, m_code, m_phase;
    bit m_ext_q, m_clk;

    function automatic int f_fold(input int c); return (c >= 4) ? 4 : c; endfunction
    function automatic int f_ratio(input int c);
        case (f_fold(c)) 0: return 1; 1: return 2; 2: return 4; 3: return 5; default: return 8; endcase
    endfunction
    function automatic int f_high(input int c);
        return (f_ratio(c) == 1) ? 1 : f_ratio(c) / 2;
    endfunction

    always @(posedge clk) begin
        int rs, rc, ns, nc, np;
        bit rise, lvl;
        if (!rst_n) begin
            m_src = 0; m_code = 3; m_phase = 4; m_ext_q = 0; m_clk = 0;
        end else begin
            rc = 0;
            if (!if_active) rs = 0;
            else if (sync_mode) rs = sync_clk_en ? 4 : (force_low ? 2 : (force_high ? 3 : 2));
            else if (sel_internal) rs = 1;
            else if (force_low) rs = 2;
            else if (force_high) rs = 3;
            else begin rs = 5; rc = f_fold(int'(div_code)); end
            ns = m_src; nc = m_code;
            if (!if_active) ns = 0;
            else if ((rs != m_src || rc != m_code) && (!m_clk || m_src == 3)) begin ns = rs; nc = rc; end
            rise = ext_clk && !m_ext_q;
            np = m_phase;
            if (ns != m_src || nc != m_code) np = f_ratio(nc) - 1;
            else if (rise) np = (m_phase >= f_ratio(nc) - 1) ? 0 : m_phase + 1;
            case (ns)
                1: lvl = int_ref;
                3: lvl = 1;
                4: lvl = ext_clk;
                5: lvl = (nc == 0) ? ext_clk : (np < f_high(nc));
                default: lvl = 0;
            endcase
            m_src = ns; m_code = nc; m_phase = np; m_ext_q = ext_clk; m_clk = lvl;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (card_clk !== m_clk) begin
                errors++;
                $display("FAIL R10 R11 model compare t=%0t: card_clk=%0b expected %0b", $time, card_clk, m_clk);
            end
            checks++;
            if (int_ref_active !== (m_src == 1)) begin
                errors++;
                $display("FAIL R3 status compare t=%0t: int_ref_active=%0b expected %0b",
                         $time, int_ref_active, (m_src == 1));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure one full output period in system cycles
    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk);
        while (card_clk && guard < 2000) begin @(negedge clk); guard++; end
        while (!card_clk && guard < 2000) begin @(negedge clk); guard++; end
        while (card_clk && guard < 2000) begin hi++; @(negedge clk); guard++; end
        while (!card_clk && guard < 2000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic set_div(input logic [2:0] c);
        sync_mode = 0; sel_internal = 0; force_low = 0; force_high = 0; div_code = c;
        cycles(120);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int hi, lo, cnt;
        void'($urandom(32'h5eed_1234));
        cycles(4);
        check("R1 reset card_clk", int'(card_clk), 0);
        check("R1 reset status", int'(int_ref_active), 0);
        rst_n = 1;
        cycles(10);
        check("R1 inactive low", int'(card_clk), 0);

        if_active = 1;
        set_div(3'b011); measure(hi, lo);
        check("R6 div5 high", hi, 12); check("R6 div5 low", lo, 18);
        set_div(3'b001); measure(hi, lo);
        check("R5 div2 high", hi, 6); check("R5 div2 low", lo, 6);
        set_div(3'b010); measure(hi, lo);
        check("R5 div4 high", hi, 12); check("R5 div4 low", lo, 12);
        set_div(3'b101); measure(hi, lo);
        check("R7 code101 high", hi, 24); check("R7 code101 low", lo, 24);
        set_div(3'b111); measure(hi, lo);
        check("R7 code111 high", hi, 24); check("R7 code111 low", lo, 24);
        set_div(3'b000); measure(hi, lo);
        check("R4 pass high", hi, 3); check("R4 pass low", lo, 3);

        // R10: a pending change keeps the running high pulse whole
        set_div(3'b100);
        @(negedge clk);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        cnt = 0;
        while (card_clk && cnt < 100) begin
            cnt++;
            if (cnt == 5) div_code = 3'b001;
            @(negedge clk);
        end
        check("R10 full high pulse kept", cnt, 24);
        measure(hi, lo);
        check("R10 new ratio high", hi, 6); check("R10 new ratio low", lo, 6);

        // R2 / R3 priority
        sel_internal = 1; force_low = 1; force_high = 1; cycles(60);
        check("R3 internal in use", int'(int_ref_active), 1);
        measure(hi, lo);
        check("R2 internal ref high", hi, 5);
        sel_internal = 0; cycles(40);
        check("R3 status dropped", int'(int_ref_active), 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += int'(card_clk); end
        check("R2 force low over high", cnt, 0);
        force_low = 0; cycles(5);
        check("R2 force high", int'(card_clk), 1);
        force_high = 0; div_code = 3'b011; cycles(60); measure(hi, lo);
        check("R2 divider last", hi, 12);

        // R8 / R9 synchronous mode
        sync_mode = 1; sync_clk_en = 1; sel_internal = 1; div_code = 3'b011; cycles(60);
        measure(hi, lo);
        check("R8 sync follows input high", hi, 3); check("R8 sync follows input low", lo, 3);
        check("R3 sync ignores internal", int'(int_ref_active), 0);
        sync_clk_en = 0; force_high = 1; cycles(30);
        check("R9 static high", int'(card_clk), 1);
        force_low = 1; cycles(5);
        check("R9 low wins", int'(card_clk), 0);
        force_low = 0; force_high = 0; cycles(5);
        check("R9 neither set", int'(card_clk), 0);

        // R1 deactivation
        sync_mode = 0; sel_internal = 0; force_low = 0; force_high = 1; cycles(20);
        if_active = 0; @(negedge clk);
        check("R1 drop to low", int'(card_clk), 0);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(card_clk); end
        check("R1 held low", cnt, 0);

        // constrained random segments, checked by the model every cycle
        for (int s = 0; s < 80; s++) begin
            if_active    = ($urandom % 8) != 0;
            sync_mode    = ($urandom % 4) == 0;
            sync_clk_en  = $urandom % 2;
            sel_internal = ($urandom % 4) == 0;
            force_low    = ($urandom % 5) == 0;
            force_high   = ($urandom % 5) == 0;
            div_code     = 3'($urandom % 8);
            ext_half     = 1 + ($urandom % 4);
            cycles(40 + ($urandom % 120));
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule